// File: doc/BRIEF.md
# Sync-Gated Programmable Clock Divider

This block divides its input clock by a programmable ratio and lets an external sync pulse realign the phase of the divided output. Before the pulse can have any effect it passes through a two-flop synchronizer and a rising-edge detector in the input clock domain. It then has to clear a gate that a small control byte holds.

The control byte has three bits. The main switch is `master` (bit 0). The realignment gate is `sync_en` (bit 1). The single-capture selector is `once` (bit 2). Software writes the byte through a plain write port with address, data and strobe, and reads it back on a combinational output.

A sync edge that passes the gate resets the divider counter, so the divided output restarts high on the next input clock. In single-capture mode the first accepted edge also clears `sync_en`, so later pulses are ignored until software sets it again.

Top module: `clkdiv_sync_ctrl`

## Requirements
- R1: While reset is asserted, `ctrl_rd_data` reads 0x00 and `div_clk_out` is 0.
- R2: `ctrl_rd_data` bits [7:3] always read zero. Bits [2:0] return the last value written to the control address, with bit 0 = master, bit 1 = sync_en, bit 2 = once.
- R3: A write strobe to any address other than `CTRL_ADDR` (default 5) leaves the control byte unchanged.
- R4: With ratio N >= 2 and no accepted sync edge, `div_clk_out` has period N input clocks. It is high for floor(N/2) cycles from counter value 0, then low for the rest of the period.
- R5: When master is 0, sync pulses have no effect on the divider, whatever sync_en and once hold.
- R6: When master is 1 and sync_en is 0, sync pulses have no effect on the divider.
- R7: With master=1, sync_en=1 and once=0, every accepted rising edge realigns the divider. If `sync_in` first reads high in cycle c, then at clock edge c+3 the counter goes to 0 and `div_clk_out` goes high.
- R8: With all three bits set, the first accepted edge realigns the divider and clears sync_en, so the readback shows 0x05. Later pulses are ignored.
- R9: A control write in the same cycle as a self-clear takes priority, and the written value is stored.
- R10: A ratio below 2 passes the input clock straight to `div_clk_out`, and sync pulses then have no visible effect.
- R11: `sync_in` held high counts as one edge only. The divider runs freely after the single realignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr_en | input | 1 | Register write strobe |
| ctrl_addr | input | ADDR_W | Register write address |
| ctrl_wr_data | input | 8 | Register write data |
| ctrl_rd_data | output | 8 | Control byte readback |
| div_ratio | input | RATIO_W | Divide ratio N |
| sync_in | input | 1 | Asynchronous sync pulse |
| div_clk_out | output | 1 | Divided (or passed-through) clock |

## Verification
The bench keeps the default parameters: a 4-bit ratio, control address 5, and two synchronizer stages. That fixes the sync-to-realignment latency at three edges. The bench runs the odd ratio 5, the even ratio 4 and the bypass ratio 1.

Before each pulse, the bench waits until the running phase would be low at the realignment edge. An ignored pulse and an accepted pulse therefore predict different output values. The same-cycle write race and the held-high level can be reached cycle-exactly from the ports.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic once;
        logic sync_en;
        logic master;
    } sync_ctrl_t;

    localparam int CTRL_BITS = $bits(sync_ctrl_t);

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(sync_ctrl_t c);
        return {{(BYTE_W-CTRL_BITS){1'b0}}, c};
    endfunction

    function automatic sync_ctrl_t bits_to_ctrl(logic [CTRL_BITS-1:0] b);
        return sync_ctrl_t'(b);
    endfunction

    function automatic logic sync_gate(sync_ctrl_t c, logic edge_seen);
        return edge_seen & c.master & c.sync_en;
    endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES:0] chain;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign rise = chain[LAST] & ~chain[STAGES];
endmodule

// File: rtl/sync_ctrl_reg.sv
module sync_ctrl_reg
    import clkdiv_pkg::*;
#(
    parameter int          ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CTRL_BITS-1:0] wr_bits,
    input  logic                 accepted,
    output sync_ctrl_t           ctrl_q
);
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(CTRL_ADDR));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (hit) begin
            ctrl_q <= bits_to_ctrl(wr_bits);
        end else if (accepted && ctrl_q.once) begin
            ctrl_q.sync_en <= 1'b0;
        end
    end
endmodule

// File: rtl/div_counter.sv
module div_counter #(
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio,
    input  logic               realign,
    output logic [RATIO_W-1:0] cnt_q,
    output logic               div_q
);
    logic [RATIO_W-1:0] last_val;
    logic [RATIO_W-1:0] half;
    logic [RATIO_W-1:0] cnt_d;

    assign last_val = ratio - 1'b1;
    assign half     = ratio >> 1;

    always_comb begin
        if (realign || cnt_q >= last_val) cnt_d = '0;
        else                              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            div_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            div_q <= (cnt_d < half);
        end
    end
endmodule

// File: rtl/clkdiv_sync_ctrl.sv
module clkdiv_sync_ctrl
    import clkdiv_pkg::*;
#(
    parameter int          ADDR_W      = 4,
    parameter int unsigned CTRL_ADDR   = 5,
    parameter int          RATIO_W     = 4,
    parameter int          SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ctrl_wr_en,
    input  logic [ADDR_W-1:0]  ctrl_addr,
    input  logic [7:0]         ctrl_wr_data,
    output logic [7:0]         ctrl_rd_data,
    input  logic [RATIO_W-1:0] div_ratio,
    input  logic               sync_in,
    output logic               div_clk_out
);
    sync_ctrl_t         ctrl_q;
    logic               sync_rise;
    logic               sync_accept;
    logic [RATIO_W-1:0] cnt_q;
    logic               div_q;
    logic               bypass;
    logic               unused_hi;

    assign unused_hi = ^ctrl_wr_data[7:CTRL_BITS];

    sync_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .async_in (sync_in),
        .rise     (sync_rise)
    );

    assign sync_accept = sync_gate(ctrl_q, sync_rise);

    sync_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctrl_wr_en),
        .addr     (ctrl_addr),
        .wr_bits  (ctrl_wr_data[CTRL_BITS-1:0]),
        .accepted (sync_accept),
        .ctrl_q   (ctrl_q)
    );

    div_counter #(.RATIO_W(RATIO_W)) u_div (
        .clk     (clk),
        .rst     (rst),
        .ratio   (div_ratio),
        .realign (sync_accept),
        .cnt_q   (cnt_q),
        .div_q   (div_q)
    );

    assign ctrl_rd_data = ctrl_to_byte(ctrl_q);
    assign bypass       = (div_ratio < RATIO_W'(2));
    assign div_clk_out  = bypass ? clk : div_q;
endmodule

// File: rtl/clkdiv_sync_chk.sv
module clkdiv_sync_chk #(
    parameter int          ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 5,
    parameter int          RATIO_W   = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [7:0]         wr_data,
    input logic [7:0]         rd_data,
    input logic [RATIO_W-1:0] ratio,
    input logic               accept,
    input logic [RATIO_W-1:0] cnt,
    input logic               div_q
);
    logic ctrl_hit;
    assign ctrl_hit = wr_en && (addr == ADDR_W'(CTRL_ADDR));

    // R7
    realign_zero_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (cnt == '0));

    // R5 R6
    gated_jump_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && $past(ratio) >= RATIO_W'(2) && $past(cnt) != '0 &&
         $past(cnt) < $past(ratio) - 1'b1) |-> ($past(rd_data[1:0]) == 2'b11));

    // R8
    once_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && rd_data[2] && !ctrl_hit) |=> !rd_data[1]);

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_hit |=> (rd_data[2:0] == $past(wr_data[2:0])));

    // R4
    duty_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ratio >= RATIO_W'(2) && $past(ratio) == ratio)
        |-> (div_q == (cnt < (ratio >> 1))));
endmodule

bind clkdiv_sync_ctrl clkdiv_sync_chk #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .RATIO_W(RATIO_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ctrl_wr_en),
    .addr    (ctrl_addr),
    .wr_data (ctrl_wr_data),
    .rd_data (ctrl_rd_data),
    .ratio   (div_ratio),
    .accept  (sync_accept),
    .cnt     (cnt_q),
    .div_q   (div_q)
);

// File: tb/tb_clkdiv_sync_ctrl.sv
`timescale 1ns/1ps
module tb_clkdiv_sync_ctrl;
    localparam int CTRL = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rd;
    logic [3:0] ratio = 4'd5;
    logic       sync_in = 1'b0;
    logic       out;

    clkdiv_sync_ctrl dut (
        .clk(clk), .rst(rst), .ctrl_wr_en(wr_en), .ctrl_addr(addr),
        .ctrl_wr_data(wdata), .ctrl_rd_data(rd), .div_ratio(ratio),
        .sync_in(sync_in), .div_clk_out(out)
    );

    always #4 clk = ~clk;

    typedef struct {
        int       at;
        bit       is_rd;
        bit [7:0] exp;
        string    req;
    } item_t;

    item_t sbq[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int nrat = 5;
    int anchor = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares scoreboard items at the falling edge
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            automatic item_t it = sbq.pop_front();
            automatic bit [7:0] act = it.is_rd ? rd : {7'b0, out};
            checks++;
            if (it.at != cyc || act !== it.exp) begin
                errors++;
                $display("FAIL %s cyc=%0d actual=%0h expected=%0h", it.req, it.at, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic push(int at, bit is_rd, bit [7:0] exp, string req);
        item_t it;
        it.at = at; it.is_rd = is_rd; it.exp = exp; it.req = req;
        sbq.push_back(it);
    endtask

    function automatic bit phase_val(int t);
        return ((t - anchor) % nrat) < (nrat / 2);
    endfunction

    task automatic expect_window(int from, int len, string req);
        for (int t = from; t < from + len; t++) push(t, 0, {7'b0, phase_val(t)}, req);
    endtask

    task automatic drain();
        while (sbq.size() > 0) tick();
    endtask

    task automatic wr(int a, bit [7:0] d);
        wr_en = 1'b1; addr = 4'(a); wdata = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(bit [7:0] e, string req);
        push(cyc + 1, 1, e, req);
        drain();
    endtask

    // advance until the old phase is low at the realignment edge
    task automatic align_low();
        while (((cyc + 3 - anchor) % nrat) != nrat / 2) tick();
    endtask

    // one pulse: accepted=1 moves the anchor
    task automatic sync_pulse(int hold, bit accepted, int win, string req);
        int c;
        c = cyc;
        sync_in = 1'b1;
        if (accepted) anchor = c + 3;
        expect_window(c + 3, win, req);
        for (int i = 0; i < hold; i++) tick();
        sync_in = 1'b0;
        drain();
    endtask

    task automatic direct(bit ok, string req, int a, int e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, a, e);
        end
    endtask

    initial begin
        tick();
        push(cyc + 1, 1, 8'h00, "R1");
        push(cyc + 1, 0, 8'h00, "R1");
        drain();
        tick(); tick();
        rst = 1'b0;
        tick();

        wr(CTRL, 8'hF8); expect_rd(8'h00, "R2");
        wr(CTRL, 8'hFF); expect_rd(8'h07, "R2");
        wr(CTRL, 8'h03); expect_rd(8'h03, "R2");
        wr(2, 8'h00);    expect_rd(8'h03, "R3");
        wr(9, 8'h07);    expect_rd(8'h03, "R3");

        // continuous realignment, ratio 5
        sync_pulse(2, 1, 10, "R4");
        align_low(); sync_pulse(2, 1, 8, "R7");
        align_low(); sync_pulse(2, 1, 8, "R7");
        // held-high level counts once
        align_low(); sync_pulse(15, 1, 15, "R11");

        // gating
        wr(CTRL, 8'h01); align_low(); sync_pulse(2, 0, 8, "R6");
        wr(CTRL, 8'h02); align_low(); sync_pulse(2, 0, 8, "R5");
        wr(CTRL, 8'h06); align_low(); sync_pulse(2, 0, 8, "R5");

        // one-shot
        wr(CTRL, 8'h07); align_low();
        push(cyc + 3, 1, 8'h05, "R8");
        sync_pulse(2, 1, 8, "R8");
        align_low(); sync_pulse(2, 0, 8, "R8");

        // write in the self-clear cycle wins
        wr(CTRL, 8'h07); align_low();
        begin
            int c;
            c = cyc;
            sync_in = 1'b1;
            anchor = c + 3;
            push(c + 3, 1, 8'h07, "R9");
            expect_window(c + 3, 8, "R9");
            tick(); tick();
            sync_in = 1'b0;
            wr_en = 1'b1; addr = 4'(CTRL); wdata = 8'h07;
            tick();
            wr_en = 1'b0;
            drain();
        end
        align_low();
        push(cyc + 3, 1, 8'h05, "R9");
        sync_pulse(2, 1, 8, "R9");

        // even ratio 4
        ratio = 4'd4; nrat = 4;
        wr(CTRL, 8'h03);
        sync_pulse(2, 1, 12, "R4");
        align_low(); sync_pulse(2, 1, 8, "R7");

        // bypass
        ratio = 4'd1;
        tick();
        for (int i = 0; i < 6; i++) begin
            if (i == 1) sync_in = 1'b1;
            if (i == 3) sync_in = 1'b0;
            @(posedge clk); #1;
            direct(out === 1'b1, "R10 high phase", int'(out), 1);
            @(negedge clk); #1;
            direct(out === 1'b0, "R10 low phase", int'(out), 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule